// File: doc/BRIEF.md
# Branch Condition Window Register File

This block holds a small file of single-bit branch conditions. A scheduler can resolve a branch early and leave the result here, so that later loop iterations steer instruction selection with it and the pipeline does not stall. The bits are grouped into partitions, one for each global conditional block of the schedule. Each partition has its own rotating pointer that names the next slot to fill.

On a fork event the microinstruction supplies a partition number, the resolved condition and two relative cycle counts, start and end. The block writes the condition into the slot the pointer names and advances that pointer. The slot then drives its condition only inside the window given by start and end. For the partition named by `sel_part_i`, the block joins the window-active conditions of its first three slots into a 3-bit offset. That offset picks one of up to eight candidate instructions, and offset 0 is the default candidate.

The partition layout comes from inputs that are sampled on every clock edge while reset is held. The layout gives a partition count and, for each partition, a base bit and a size. An illegal layout is flagged and blocks all loads.

Top module: `cond_bit_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every slot is idle and every pointer is at slot 0. `ld_en_o`, `act_o`, `offset_o` and `ovr_err_o` are all 0.
- R2: `cfg_err_o` is 1 when the sampled layout is illegal. A layout is illegal when the count is 0 or more than NPART, when a used partition has size 0, or when base+size of a used partition exceeds NBITS. While `cfg_err_o` is 1 no fork loads anything.
- R3: A fork that is accepted raises exactly one bit of `ld_en_o` in the cycle the fork is presented. That bit is base+pointer of the addressed partition. In all other cycles `ld_en_o` is 0.
- R4: Each accepted load advances the pointer of its own partition by one, and the pointer wraps to 0 after slot size-1. Pointers of other partitions do not move.
- R5: Call k=0 the first cycle after the clock edge that accepts a load. The loaded bit of `act_o` is 1 exactly for start ≤ k ≤ end, and the slot stays occupied for 0 ≤ k ≤ end.
- R6: Bit j of `offset_o` (j = 0..2) is the stored condition of slot j of the selected partition when that slot is window-active, and 0 otherwise. Slots j ≥ size, slots beyond slot 2, and a selected partition at or above the count contribute nothing. With no active slot the offset is 0.
- R7: A fork aimed at a slot that is still occupied is an overrun. It is dropped: no `ld_en_o` bit rises and the pointer does not move. `ovr_err_o` becomes 1 on the next cycle and stays 1 until reset.
- R8: A slot takes a new condition in the first cycle after its previous occupancy ended (k = end+1).
- R9: Several slots of one partition hold conditions with overlapping windows at the same time, and each slot keeps its own window.
- R10: A fork naming a partition at or above the configured count is ignored, with no load and no overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; the layout is sampled while it is low |
| cfg_nparts_i | input | PW+1 | Number of partitions in use |
| cfg_base_i | input | NPART*IW | First bit of each partition, partition 0 in the low field |
| cfg_size_i | input | NPART*SW | Number of slots of each partition, partition 0 in the low field |
| fork_vld_i | input | 1 | A fork event is presented this cycle |
| fork_part_i | input | PW | Partition addressed by the fork |
| fork_cond_i | input | 1 | Resolved branch condition |
| fork_start_i | input | CW | First active cycle, counted from the load |
| fork_end_i | input | CW | Last active cycle, counted from the load |
| sel_part_i | input | PW | Partition whose slots form the offset |
| ld_en_o | output | NBITS | One load enable per bit |
| act_o | output | NBITS | Window-active flag per bit |
| offset_o | output | OW | Candidate offset into the instruction group |
| cfg_err_o | output | 1 | Sampled layout is illegal |
| ovr_err_o | output | 1 | Sticky overrun flag |

## Verification
The offset function is exercised with three slots whose windows overlap and carry mixed condition values. This separates correct per-slot ordering and masking from a plain OR of the conditions or a swapped bit order. A full-width partition with only its fourth slot true separates truncation to three slots from wider packing. Back-to-back forks at the end of a window tell an overrun (k = end) apart from legal reuse (k = end+1). Interleaved forks to two partitions and to an unused partition index show that the pointers are independent and that out-of-range forks are ignored.

// File: rtl/cbit_pkg.sv
// Shared definitions for the branch condition window register file.
// Assumes: none beyond SystemVerilog-2017 packages.
package cbit_pkg;

    // Outcome of the layout legality check.
    typedef enum logic [1:0] {
        CFG_OK        = 2'd0,
        CFG_NO_PART   = 2'd1,
        CFG_ZERO_SIZE = 2'd2,
        CFG_OVERFLOW  = 2'd3
    } cfg_stat_e;

endpackage

// File: rtl/cbit_cfg.sv
// Layout register: samples the partition layout on every clock edge while
// reset is low and holds it afterwards, then grades the held layout.
// Assumes: the layout inputs are steady for at least the last reset cycle.
module cbit_cfg
    import cbit_pkg::*;
#(
    parameter int NBITS = 8,
    parameter int NPART = 4,
    parameter int IW    = 3,
    parameter int SW    = 4,
    parameter int PW    = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [PW:0]           nparts_i,
    input  logic [NPART*IW-1:0]   base_i,
    input  logic [NPART*SW-1:0]   size_i,
    output logic [PW:0]           nparts_o,
    output logic [NPART*IW-1:0]   base_o,
    output logic [NPART*SW-1:0]   size_o,
    output cfg_stat_e             stat_o
);

    logic [PW:0]         np_q;
    logic [NPART*IW-1:0] base_q;
    logic [NPART*SW-1:0] size_q;

    // Capture the layout while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            np_q   <= nparts_i;
            base_q <= base_i;
            size_q <= size_i;
        end
    end

    // Grade the held layout; the last failing partition sets the code.
    always_comb begin
        stat_o = CFG_OK;
        if (int'(np_q) == 0 || int'(np_q) > NPART) begin
            stat_o = CFG_NO_PART;
        end else begin
            for (int p = 0; p < NPART; p++) begin
                if (p < int'(np_q)) begin
                    if (size_q[p*SW +: SW] == '0)
                        stat_o = CFG_ZERO_SIZE;
                    else if (int'(base_q[p*IW +: IW]) + int'(size_q[p*SW +: SW]) > NBITS)
                        stat_o = CFG_OVERFLOW;
                end
            end
        end
    end

    assign nparts_o = np_q;
    assign base_o   = base_q;
    assign size_o   = size_q;

endmodule

// File: rtl/cbit_rotor.sv
// Rotation pointers: one pointer per partition that names the next slot
// to fill, and wraps at the partition size.
// Assumes: adv_i is raised only for a partition with a legal, non-zero size.
module cbit_rotor #(
    parameter int NPART = 4,
    parameter int IW    = 3,
    parameter int SW    = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NPART-1:0]      adv_i,
    input  logic [NPART*SW-1:0]   size_i,
    output logic [NPART*IW-1:0]   ptr_o
);

    for (genvar p = 0; p < NPART; p++) begin : g_part
        logic [IW-1:0] ptr_q;
        logic [SW-1:0] nxt;
        logic [SW-1:0] sz;

        assign sz  = size_i[p*SW +: SW];
        assign nxt = {1'b0, ptr_q} + 1'b1;

        // Step the pointer on each accepted load, wrapping inside the partition.
        always_ff @(posedge clk) begin
            if (!rst_n)
                ptr_q <= '0;
            else if (adv_i[p])
                ptr_q <= (nxt >= sz) ? '0 : nxt[IW-1:0];
        end

        assign ptr_o[p*IW +: IW] = ptr_q;

        // The pointer never leaves its partition.
        p_ptr_in_part_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (sz != '0) |-> ({1'b0, ptr_q} < sz));
    end

endmodule

// File: rtl/cbit_cell.sv
// One condition slot: holds a condition plus two down-counters that place
// its active window relative to the load cycle.
// Assumes: the parent never loads a slot that is still occupied.
module cbit_cell #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_i,
    input  logic          cond_i,
    input  logic [CW-1:0] start_i,
    input  logic [CW-1:0] end_i,
    output logic          busy_o,
    output logic          act_o,
    output logic          cond_o
);

    logic          busy_q;
    logic          cond_q;
    logic [CW-1:0] to_start_q;
    logic [CW-1:0] to_end_q;

    // Load a new condition, or count down the window of the held one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q     <= 1'b0;
            cond_q     <= 1'b0;
            to_start_q <= '0;
            to_end_q   <= '0;
        end else if (ld_i) begin
            busy_q     <= 1'b1;
            cond_q     <= cond_i;
            to_start_q <= start_i;
            to_end_q   <= end_i;
        end else if (busy_q) begin
            if (to_end_q == '0)
                busy_q <= 1'b0;
            else
                to_end_q <= to_end_q - 1'b1;
            if (to_start_q != '0)
                to_start_q <= to_start_q - 1'b1;
        end
    end

    assign busy_o = busy_q;
    assign act_o  = busy_q && (to_start_q == '0);
    assign cond_o = cond_q;

    // A load only reaches a free slot.
    p_load_free_slot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ld_i |-> !busy_q);

    // A load occupies the slot from the next cycle on.
    p_occupied_after_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ld_i |=> busy_o);

endmodule

// File: rtl/cbit_offset.sv
// Offset former: packs the window-active conditions of the first OW slots
// of the selected partition, slot 0 in the least significant bit.
// Assumes: the layout is legal whenever a non-zero offset matters.
module cbit_offset #(
    parameter int NBITS = 8,
    parameter int NPART = 4,
    parameter int IW    = 3,
    parameter int SW    = 4,
    parameter int PW    = 2,
    parameter int OW    = 3
) (
    input  logic [PW-1:0]         sel_i,
    input  logic [PW:0]           nparts_i,
    input  logic [NPART*IW-1:0]   base_i,
    input  logic [NPART*SW-1:0]   size_i,
    input  logic [NBITS-1:0]      act_i,
    input  logic [NBITS-1:0]      cond_i,
    output logic [OW-1:0]         offset_o
);

    logic [IW-1:0] base_sel;
    logic [SW-1:0] size_sel;
    logic          sel_ok;

    assign base_sel = base_i[sel_i*IW +: IW];
    assign size_sel = size_i[sel_i*SW +: SW];
    assign sel_ok   = ({1'b0, sel_i} < nparts_i);

    // Gather active conditions slot by slot, truncated to OW slots.
    always_comb begin
        offset_o = '0;
        for (int j = 0; j < OW; j++) begin
            logic [IW:0] idx;
            idx = {1'b0, base_sel} + (IW+1)'(j);
            if (sel_ok && (j < int'(size_sel)) && (int'(idx) < NBITS))
                offset_o[j] = act_i[idx[IW-1:0]] & cond_i[idx[IW-1:0]];
        end
    end

endmodule

// File: rtl/cond_bit_ctrl.sv
// Branch condition window register file, top level. Decodes fork events
// into per-bit load enables through per-partition rotation pointers, flags
// overruns, and forms the multi-way branch offset of a selected partition.
// Assumes: the layout is set up during reset; forks are presented for one
// cycle each and are accepted or dropped in that same cycle.
module cond_bit_ctrl
    import cbit_pkg::*;
#(
    parameter int NBITS = 8,
    parameter int NPART = 4,
    parameter int CW    = 4,
    parameter int OW    = 3,
    localparam int IW   = $clog2(NBITS),
    localparam int SW   = IW + 1,
    localparam int PW   = $clog2(NPART)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [PW:0]           cfg_nparts_i,
    input  logic [NPART*IW-1:0]   cfg_base_i,
    input  logic [NPART*SW-1:0]   cfg_size_i,
    input  logic                  fork_vld_i,
    input  logic [PW-1:0]         fork_part_i,
    input  logic                  fork_cond_i,
    input  logic [CW-1:0]         fork_start_i,
    input  logic [CW-1:0]         fork_end_i,
    input  logic [PW-1:0]         sel_part_i,
    output logic [NBITS-1:0]      ld_en_o,
    output logic [NBITS-1:0]      act_o,
    output logic [OW-1:0]         offset_o,
    output logic                  cfg_err_o,
    output logic                  ovr_err_o
);

    logic [PW:0]         np_w;
    logic [NPART*IW-1:0] base_w;
    logic [NPART*SW-1:0] size_w;
    cfg_stat_e           stat_w;
    logic [NPART*IW-1:0] ptr_w;
    logic [NPART-1:0]    adv_w;
    logic [NBITS-1:0]    busy_w;
    logic [NBITS-1:0]    cond_w;
    logic [IW:0]         tgt_w;
    logic [IW-1:0]       tgt;
    logic                fork_hit;
    logic                accept;
    logic                ovr_q;

    cbit_cfg #(
        .NBITS (NBITS), .NPART (NPART), .IW (IW), .SW (SW), .PW (PW)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .nparts_i (cfg_nparts_i),
        .base_i   (cfg_base_i),
        .size_i   (cfg_size_i),
        .nparts_o (np_w),
        .base_o   (base_w),
        .size_o   (size_w),
        .stat_o   (stat_w)
    );

    assign cfg_err_o = (stat_w != CFG_OK);

    cbit_rotor #(
        .NPART (NPART), .IW (IW), .SW (SW)
    ) u_rotor (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv_i  (adv_w),
        .size_i (size_w),
        .ptr_o  (ptr_w)
    );

    // Locate the slot the fork aims at and decide accept or overrun.
    always_comb begin
        tgt_w    = {1'b0, base_w[fork_part_i*IW +: IW]} + {1'b0, ptr_w[fork_part_i*IW +: IW]};
        tgt      = tgt_w[IW-1:0];
        fork_hit = fork_vld_i && !cfg_err_o && ({1'b0, fork_part_i} < np_w)
                   && (int'(tgt_w) < NBITS);
        accept   = fork_hit && !busy_w[tgt];
        ld_en_o  = '0;
        adv_w    = '0;
        if (accept) begin
            ld_en_o[tgt]      = 1'b1;
            adv_w[fork_part_i] = 1'b1;
        end
    end

    // Hold the overrun flag until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ovr_q <= 1'b0;
        else if (fork_hit && busy_w[tgt])
            ovr_q <= 1'b1;
    end

    assign ovr_err_o = ovr_q;

    for (genvar b = 0; b < NBITS; b++) begin : g_slot
        cbit_cell #(.CW (CW)) u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .ld_i    (ld_en_o[b]),
            .cond_i  (fork_cond_i),
            .start_i (fork_start_i),
            .end_i   (fork_end_i),
            .busy_o  (busy_w[b]),
            .act_o   (act_o[b]),
            .cond_o  (cond_w[b])
        );
    end

    cbit_offset #(
        .NBITS (NBITS), .NPART (NPART), .IW (IW), .SW (SW), .PW (PW), .OW (OW)
    ) u_offset (
        .sel_i    (sel_part_i),
        .nparts_i (np_w),
        .base_i   (base_w),
        .size_i   (size_w),
        .act_i    (act_o),
        .cond_i   (cond_w),
        .offset_o (offset_o)
    );

    // At most one load enable per cycle.
    p_single_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ld_en_o));

    // An illegal layout blocks every load.
    p_bad_cfg_no_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err_o |-> (ld_en_o == '0));

    // The overrun flag is sticky.
    p_ovr_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_err_o |=> ovr_err_o);

    // No active slot means the default candidate.
    p_idle_offset_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (act_o == '0) |-> (offset_o == '0));

endmodule

// File: tb/tb_cond_bit_ctrl.sv
// Scoreboard bench: the driver queues expected port values tagged with
// the cycle they are due; a monitor compares them after each falling edge.
module tb_cond_bit_ctrl;

    localparam int NBITS = 8;
    localparam int NPART = 4;
    localparam int CW    = 4;
    localparam int OW    = 3;
    localparam int IW    = 3;
    localparam int SW    = 4;
    localparam int PW    = 2;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [PW:0]         cfg_nparts = '0;
    logic [NPART*IW-1:0] cfg_base = '0;
    logic [NPART*SW-1:0] cfg_size = '0;
    logic                fork_vld = 1'b0;
    logic [PW-1:0]       fork_part = '0;
    logic                fork_cond = 1'b0;
    logic [CW-1:0]       fork_start = '0;
    logic [CW-1:0]       fork_end = '0;
    logic [PW-1:0]       sel_part = '0;
    logic [NBITS-1:0]    ld_en;
    logic [NBITS-1:0]    act;
    logic [OW-1:0]       offset;
    logic                cfg_err;
    logic                ovr_err;

    cond_bit_ctrl #(.NBITS (NBITS), .NPART (NPART), .CW (CW), .OW (OW)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_nparts_i (cfg_nparts),
        .cfg_base_i   (cfg_base),
        .cfg_size_i   (cfg_size),
        .fork_vld_i   (fork_vld),
        .fork_part_i  (fork_part),
        .fork_cond_i  (fork_cond),
        .fork_start_i (fork_start),
        .fork_end_i   (fork_end),
        .sel_part_i   (sel_part),
        .ld_en_o      (ld_en),
        .act_o        (act),
        .offset_o     (offset),
        .cfg_err_o    (cfg_err),
        .ovr_err_o    (ovr_err)
    );

    always #2 clk = ~clk;

    int cyc = 0;
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    localparam int K_LD = 0, K_OFF = 1, K_ACT = 2, K_OVR = 3, K_CFG = 4;

    typedef struct {
        int    cyc;
        int    kind;
        int    val;
        string tag;
    } exp_t;

    exp_t q[$];

    function automatic void expect_at(int c, int kind, int val, string tag);
        exp_t e;
        e.cyc = c; e.kind = kind; e.val = val; e.tag = tag;
        q.push_back(e);
    endfunction

    function automatic int sample(int kind);
        case (kind)
            K_LD:    return int'(ld_en);
            K_OFF:   return int'(offset);
            K_ACT:   return int'(act);
            K_OVR:   return int'(ovr_err);
            default: return int'(cfg_err);
        endcase
    endfunction

    // Monitor: compare every item due in this cycle.
    always @(negedge clk) begin
        #1;
        for (int i = q.size() - 1; i >= 0; i--) begin
            if (q[i].cyc == cyc) begin
                int got;
                got = sample(q[i].kind);
                total++;
                if (got != q[i].val) begin
                    bad++;
                    $display("FAIL %s kind=%0d cyc=%0d actual=%0d expected=%0d",
                             q[i].tag, q[i].kind, cyc, got, q[i].val);
                end
                q.delete(i);
            end
        end
    end

    task automatic do_reset(int np, logic [NPART*IW-1:0] b, logic [NPART*SW-1:0] s);
        @(negedge clk);
        rst_n      = 1'b0;
        fork_vld   = 1'b0;
        cfg_nparts = np[PW:0];
        cfg_base   = b;
        cfg_size   = s;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Present one fork for one cycle; exp_bit < 0 means no load expected.
    task automatic fork_op(int p, int c, int st, int en, int exp_bit, string tag);
        fork_vld   = 1'b1;
        fork_part  = p[PW-1:0];
        fork_cond  = c[0];
        fork_start = st[CW-1:0];
        fork_end   = en[CW-1:0];
        expect_at(cyc, K_LD, (exp_bit < 0) ? 0 : (1 << exp_bit), tag);
        @(negedge clk);
        fork_vld = 1'b0;
    endtask

    int c0;

    initial begin
        // Layout A: P0 = bits 0..2, P1 = bits 3..4, P2 = bits 5..7.
        do_reset(3, {3'd0, 3'd5, 3'd3, 3'd0}, {4'd0, 4'd3, 4'd2, 4'd3});
        expect_at(cyc, K_LD,  0, "R1 ld_en after reset");
        expect_at(cyc, K_ACT, 0, "R1 act after reset");
        expect_at(cyc, K_OFF, 0, "R1 offset after reset");
        expect_at(cyc, K_OVR, 0, "R1 ovr after reset");
        expect_at(cyc, K_CFG, 0, "R2 legal layout");
        @(negedge clk);

        // Overlapping windows in P0, overrun, then reuse.
        sel_part = 2'd0;
        c0 = cyc;
        expect_at(c0+1, K_ACT, 0, "R5 not yet started");
        expect_at(c0+2, K_ACT, 3, "R9 two windows overlap");
        expect_at(c0+3, K_ACT, 7, "R9 three windows overlap");
        expect_at(c0+4, K_ACT, 2, "R5 windows closed at end");
        expect_at(c0+5, K_ACT, 3, "R8 reused slot active");
        expect_at(c0+6, K_ACT, 0, "R5 all windows closed");
        expect_at(c0+2, K_OFF, 1, "R6 offset slot0");
        expect_at(c0+3, K_OFF, 5, "R6 offset slots 0 and 2");
        expect_at(c0+4, K_OFF, 0, "R6 active false condition");
        expect_at(c0+5, K_OFF, 1, "R6 offset after reuse");
        expect_at(c0+6, K_OFF, 0, "R6 idle offset zero");
        expect_at(c0+3, K_OVR, 0, "R7 no overrun yet");
        expect_at(c0+4, K_OVR, 1, "R7 overrun flagged");
        expect_at(c0+8, K_OVR, 1, "R7 overrun sticky");
        fork_op(0, 1, 1, 2,  0, "R3 load slot0");
        fork_op(0, 0, 0, 3,  1, "R4 pointer to slot1");
        fork_op(0, 1, 0, 0,  2, "R4 pointer to slot2");
        fork_op(0, 1, 0, 0, -1, "R7 busy slot dropped");
        fork_op(0, 1, 0, 0,  0, "R8 reuse after window");
        repeat (4) @(negedge clk);

        // P1 wrap, unused partition, independent pointers.
        sel_part = 2'd1;
        c0 = cyc;
        expect_at(c0+1, K_OFF, 1, "R6 P1 slot0");
        expect_at(c0+2, K_OFF, 2, "R6 P1 slot1");
        expect_at(c0+2, K_ACT, 8'h10, "R5 P1 slot1 window");
        expect_at(c0+3, K_OFF, 0, "R10 ignored fork leaves none");
        expect_at(c0+4, K_OFF, 1, "R4 P1 wrapped to slot0");
        expect_at(c0+5, K_ACT, 8'h02, "R4 P0 pointer kept");
        expect_at(c0+6, K_ACT, 8'h20, "R4 P2 first slot");
        fork_op(1, 1, 0, 0,  3, "R3 P1 slot0");
        fork_op(1, 1, 0, 0,  4, "R3 P1 slot1");
        fork_op(3, 1, 0, 0, -1, "R10 partition beyond count");
        fork_op(1, 1, 0, 0,  3, "R4 P1 wrap");
        fork_op(0, 1, 0, 0,  1, "R4 P0 independent");
        fork_op(2, 1, 0, 0,  5, "R4 P2 independent");
        repeat (3) @(negedge clk);

        // Layout B: one partition of all 8 bits; truncation to 3 slots.
        do_reset(1, {3'd0, 3'd0, 3'd0, 3'd0}, {4'd0, 4'd0, 4'd0, 4'd8});
        sel_part = 2'd0;
        c0 = cyc;
        expect_at(c0, K_OVR, 0, "R1 reset clears overrun");
        expect_at(c0, K_CFG, 0, "R2 full-width layout legal");
        expect_at(c0+4, K_ACT, 8'h0F, "R9 four overlapping");
        expect_at(c0+4, K_OFF, 0, "R6 slot3 truncated");
        expect_at(c0+5, K_ACT, 8'h0F, "R10 ignored fork no change");
        fork_op(0, 0, 0, 8,  0, "R3 B slot0");
        fork_op(0, 0, 0, 8,  1, "R3 B slot1");
        fork_op(0, 0, 0, 8,  2, "R3 B slot2");
        fork_op(0, 1, 0, 8,  3, "R3 B slot3");
        fork_op(1, 1, 0, 0, -1, "R10 B partition1 unused");
        repeat (2) @(negedge clk);

        // Layout C: zero-size partition is illegal and blocks loads.
        do_reset(2, {3'd0, 3'd0, 3'd4, 3'd0}, {4'd0, 4'd0, 4'd0, 4'd4});
        c0 = cyc;
        expect_at(c0, K_CFG, 1, "R2 zero size flagged");
        expect_at(c0+1, K_ACT, 0, "R2 blocked load inactive");
        fork_op(0, 1, 0, 0, -1, "R2 load blocked");
        repeat (2) @(negedge clk);

        // Layout D: partition runs past the last bit.
        do_reset(1, {3'd0, 3'd0, 3'd0, 3'd6}, {4'd0, 4'd0, 4'd0, 4'd4});
        expect_at(cyc, K_CFG, 1, "R2 overflow flagged");
        fork_op(0, 1, 0, 0, -1, "R2 overflow blocks load");
        repeat (3) @(negedge clk);

        if (q.size() != 0) begin
            bad += q.size();
            total += q.size();
            $display("FAIL R1 scoreboard leftover actual=%0d expected=0", q.size());
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R1 watchdog actual=timeout expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule